// File: doc/BRIEF.md
# Ternary Route Prefix Lookup Table

This block holds a small table of route prefixes and answers lookups against it. Each of the entries keeps a stored address value, a care mask and an egress hop code. The care mask is built from a prefix length at write time: the leading `len` bits of the address are compared and the remaining bits are don't care, so a don't-care bit matches either key value. A lookup compares the key against every entry at once. A lowest-index picker then selects one of the matching entries.

Two lookup modes are chosen by the `mode` input. With `mode` = 0 (ordered), priority follows table position. Software must store longer prefixes at lower indices. Because inserting into an ordered table is not incremental, writes are taken only inside a reload sequence, which starts by invalidating the whole table and holds `busy` high until it is closed. With `mode` = 1 (length priority), entries may sit in any order and may be written at any idle time. A lookup then runs a binary search over the stored prefix lengths. Each step asks whether any matching entry has length at least a trial value and narrows the range. A final cycle returns the lowest-index entry at the length that was found.

The controller has four states. IDLE accepts lookups, writes (length-priority mode only) and reload requests. RELOAD is entered from IDLE on `reload_req` in ordered mode and goes back to IDLE on `reload_done`. PSRCH is entered from IDLE when a length-priority lookup is accepted and runs LEN_W narrowing steps. FINISH follows the last step, issues the result and goes back to IDLE.

Top module: `tcam_route_lookup`

## Requirements
- R1: An entry written with length L compares only the L most significant key bits against its stored value. A length of 0 matches every key, and lengths above 32 count as 32.
- R2: In ordered mode (`mode`=0), a lookup accepted in IDLE gives `res_valid`=1 after exactly one clock edge. The result is the lowest-index valid matching entry.
- R3: When no valid entry matches, the result has `res_hit`=0, `res_idx`=0 and `res_hop`=0. An entry written with `wr_valid`=0 never matches.
- R4: In ordered mode, `reload_req` in IDLE invalidates every entry and raises `busy` until `reload_done`. This request takes precedence over a lookup in the same cycle. A write in ordered mode outside a reload has no effect.
- R5: In length-priority mode (`mode`=1), the result is the matching entry with the greatest prefix length, with ties going to the lowest index. It appears exactly LEN_W+2 (8) clock edges after the lookup is accepted.
- R6: During a length-priority lookup `busy` is high, and further lookup requests are ignored. Each accepted lookup gives exactly one `res_valid` pulse.
- R7: In length-priority mode, a write in IDLE updates one entry without disturbing the others.
- R8: `res_valid` is a single-cycle pulse for each accepted lookup. `res_hit`, `res_idx` and `res_hop` hold until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, invalidates all entries |
| mode | input | 1 | 0 = ordered priority, 1 = prefix-length priority |
| reload_req | input | 1 | Begin a table reload (ordered mode) |
| reload_done | input | 1 | Close the table reload |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Entry index to write |
| wr_valid | input | 1 | Valid bit stored with the entry |
| wr_prefix | input | 32 | Prefix value |
| wr_len | input | 6 | Prefix length, 0 to 32 |
| wr_hop | input | 8 | Egress hop code |
| srch_valid | input | 1 | Lookup request |
| srch_key | input | 32 | Lookup key |
| busy | output | 1 | Controller outside IDLE |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | A valid entry matched |
| res_idx | output | 4 | Selected entry index |
| res_hop | output | 8 | Hop code of the selected entry |

## Verification
A corrupted care mask or stored value shows up on the first lookup whose key differs from the prefix in the affected bit range. That result is wrong in `res_hit` or `res_idx` one edge after an ordered lookup is accepted. A wrong narrowing step in the length search gives a shorter prefix's index at the FINISH result, eight edges after acceptance. This is exercised with nested prefixes placed out of length order. A controller left in the wrong state shows as `busy` stuck high, as a missing or doubled `res_valid` pulse, or as an ordered write that lands outside a reload.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RELOAD = 2'd1,
        ST_PSRCH  = 2'd2,
        ST_FINISH = 2'd3
    } lookup_state_t;

    localparam logic MODE_ORDERED = 1'b0;
    localparam logic MODE_LENPRIO = 1'b1;
endpackage

// File: rtl/tcam_entry_array.sv
module tcam_entry_array #(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 32,
    parameter int HOP_W   = 8,
    parameter int LEN_W   = 6,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_all,
    input  logic               wr_fire,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [KEY_W-1:0]   wr_prefix,
    input  logic [LEN_W-1:0]   wr_len,
    input  logic [HOP_W-1:0]   wr_hop,
    input  logic [KEY_W-1:0]   cmp_key,
    input  logic [LEN_W-1:0]   thr,
    output logic [ENTRIES-1:0] match_vec,
    output logic [ENTRIES-1:0] ge_vec,
    output logic [ENTRIES-1:0] eq_vec,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [HOP_W-1:0]   rd_hop
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(KEY_W);

    logic [LEN_W-1:0] len_clamped;
    logic [KEY_W-1:0] care_new;
    logic [HOP_W-1:0] hop_mem [ENTRIES];

    always_comb begin
        len_clamped = (wr_len > MAX_LEN) ? MAX_LEN : wr_len;
        care_new    = ~({KEY_W{1'b1}} >> len_clamped);
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        logic             vld_q;
        logic [KEY_W-1:0] val_q;
        logic [KEY_W-1:0] care_q;
        logic [LEN_W-1:0] len_q;
        logic [HOP_W-1:0] hop_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                val_q  <= '0;
                care_q <= '0;
                len_q  <= '0;
                hop_q  <= '0;
            end else if (clr_all) begin
                vld_q <= 1'b0;
            end else if (wr_fire && wr_idx == IDX_W'(g)) begin
                vld_q  <= wr_valid;
                val_q  <= wr_prefix & care_new;
                care_q <= care_new;
                len_q  <= len_clamped;
                hop_q  <= wr_hop;
            end
        end

        assign match_vec[g] = vld_q && (((cmp_key ^ val_q) & care_q) == '0);
        assign ge_vec[g]    = match_vec[g] && (len_q >= thr);
        assign eq_vec[g]    = match_vec[g] && (len_q == thr);
        assign hop_mem[g]   = hop_q;
    end

    assign rd_hop = hop_mem[rd_idx];
endmodule

// File: rtl/tcam_low_pick.sv
module tcam_low_pick #(
    parameter int N     = 16,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
        found = |req;
    end
endmodule

// File: rtl/tcam_route_lookup.sv
module tcam_route_lookup
    import tcam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int KEY_W   = 32,
    parameter int HOP_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int LEN_W  = $clog2(KEY_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode,
    input  logic             reload_req,
    input  logic             reload_done,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [HOP_W-1:0] wr_hop,
    input  logic             srch_valid,
    input  logic [KEY_W-1:0] srch_key,
    output logic             busy,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [HOP_W-1:0] res_hop
);
    localparam int STEP_W = $clog2(LEN_W) + 1;
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(LEN_W - 1);
    localparam logic [LEN_W-1:0]  MAX_LEN   = LEN_W'(KEY_W);

    lookup_state_t state_q, state_d;

    logic [KEY_W-1:0]   key_q;
    logic [LEN_W-1:0]   lo_q, hi_q, mid;
    logic [STEP_W-1:0]  step_q;
    logic               acc_ord, acc_pri, reload_go, wr_fire;
    logic [KEY_W-1:0]   cmp_key;
    logic [LEN_W-1:0]   thr;
    logic [ENTRIES-1:0] match_vec, ge_vec, eq_vec, pick_req;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic [HOP_W-1:0]   pick_hop;

    // request decode in IDLE; reload wins over a same-cycle ordered lookup
    assign reload_go = (state_q == ST_IDLE) && mode == MODE_ORDERED && reload_req;
    assign acc_ord   = (state_q == ST_IDLE) && mode == MODE_ORDERED && srch_valid && !reload_req;
    assign acc_pri   = (state_q == ST_IDLE) && mode == MODE_LENPRIO && srch_valid;
    assign wr_fire   = wr_en && ((state_q == ST_RELOAD) ||
                                 (state_q == ST_IDLE && mode == MODE_LENPRIO));
    assign busy      = (state_q != ST_IDLE);

    assign mid      = lo_q + ((hi_q - lo_q + LEN_W'(1)) >> 1);
    assign cmp_key  = (state_q == ST_IDLE) ? srch_key : key_q;
    assign thr      = (state_q == ST_FINISH) ? lo_q : mid;
    assign pick_req = (state_q == ST_FINISH) ? eq_vec : match_vec;

    tcam_entry_array #(
        .ENTRIES(ENTRIES), .KEY_W(KEY_W), .HOP_W(HOP_W), .LEN_W(LEN_W), .IDX_W(IDX_W)
    ) array_i (
        .clk(clk), .rst_n(rst_n), .clr_all(reload_go), .wr_fire(wr_fire),
        .wr_idx(wr_idx), .wr_valid(wr_valid), .wr_prefix(wr_prefix),
        .wr_len(wr_len), .wr_hop(wr_hop), .cmp_key(cmp_key), .thr(thr),
        .match_vec(match_vec), .ge_vec(ge_vec), .eq_vec(eq_vec),
        .rd_idx(pick_idx), .rd_hop(pick_hop)
    );

    tcam_low_pick #(.N(ENTRIES), .IDX_W(IDX_W)) pick_i (
        .req(pick_req), .found(pick_found), .idx(pick_idx)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (reload_go)    state_d = ST_RELOAD;
                else if (acc_pri) state_d = ST_PSRCH;
            end
            ST_RELOAD: if (reload_done) state_d = ST_IDLE;
            ST_PSRCH:  if (step_q == LAST_STEP) state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // length binary-search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            step_q <= '0;
        end else if (acc_pri) begin
            key_q  <= srch_key;
            lo_q   <= '0;
            hi_q   <= MAX_LEN;
            step_q <= '0;
        end else if (state_q == ST_PSRCH) begin
            step_q <= step_q + STEP_W'(1);
            if (lo_q < hi_q) begin
                if (|ge_vec) lo_q <= mid;
                else         hi_q <= mid - LEN_W'(1);
            end
        end
    end

    // result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_hop   <= '0;
        end else begin
            res_valid <= 1'b0;
            if (acc_ord || state_q == ST_FINISH) begin
                res_valid <= 1'b1;
                res_hit   <= pick_found;
                res_idx   <= pick_found ? pick_idx : '0;
                res_hop   <= pick_found ? pick_hop : '0;
            end
        end
    end
endmodule

// File: rtl/tcam_route_lookup_chk.sv
module tcam_route_lookup_chk
    import tcam_pkg::*;
#(
    parameter int IDX_W = 4,
    parameter int HOP_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode,
    input logic             reload_req,
    input logic             srch_valid,
    input logic             busy,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_idx,
    input logic [HOP_W-1:0] res_hop,
    input lookup_state_t    state_q
);
    a_r2_ordered_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && srch_valid && mode == 1'b0 && !reload_req) |=> res_valid);

    a_r3_miss_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_idx == '0 && res_hop == '0));

    a_r4_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && mode == 1'b0 && reload_req) |=> busy);

    a_r5_finish_result: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FINISH) |=> (res_valid && !busy));

    a_r6_quiet_search: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PSRCH) |=> !res_valid);

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && mode == 1'b1) |=> !res_valid);
endmodule

bind tcam_route_lookup tcam_route_lookup_chk #(.IDX_W(IDX_W), .HOP_W(HOP_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reload_req(reload_req),
    .srch_valid(srch_valid), .busy(busy), .res_valid(res_valid),
    .res_hit(res_hit), .res_idx(res_idx), .res_hop(res_hop), .state_q(state_q)
);

// File: tb/tcam_route_lookup_tb.sv
module tcam_route_lookup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        reload_req = 1'b0, reload_done = 1'b0;
    logic        wr_en = 1'b0, wr_valid = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_prefix = '0;
    logic [5:0]  wr_len = '0;
    logic [7:0]  wr_hop = '0;
    logic        srch_valid = 1'b0;
    logic [31:0] srch_key = '0;
    logic        busy, res_valid, res_hit;
    logic [3:0]  res_idx;
    logic [7:0]  res_hop;

    int total = 0;
    int bad = 0;

    // bench-side model of the table
    logic        m_vld [N];
    logic [31:0] m_val [N];
    int          m_len [N];
    logic [7:0]  m_hop [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    tcam_route_lookup dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .reload_req(reload_req),
        .reload_done(reload_done), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_prefix(wr_prefix), .wr_len(wr_len),
        .wr_hop(wr_hop), .srch_valid(srch_valid), .srch_key(srch_key),
        .busy(busy), .res_valid(res_valid), .res_hit(res_hit),
        .res_idx(res_idx), .res_hop(res_hop)
    );

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic m_match(input int i, input logic [31:0] key);
        logic [31:0] care;
        care = (m_len[i] == 0) ? 32'h0 : ~(32'hFFFF_FFFF >> m_len[i]);
        return m_vld[i] && (((key ^ m_val[i]) & care) == 32'h0);
    endfunction

    task automatic model(input logic pri, input logic [31:0] key,
                         output logic hit, output int idx, output int hop);
        int best;
        hit = 1'b0; idx = 0; hop = 0; best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_match(i, key)) begin
                if (!pri && !hit) begin hit = 1'b1; idx = i; hop = int'(m_hop[i]); end
                if (pri && m_len[i] > best) begin
                    best = m_len[i]; hit = 1'b1; idx = i; hop = int'(m_hop[i]);
                end
            end
        end
    endtask

    task automatic write_entry(input int idx, input logic vld, input logic [31:0] pfx,
                               input int len, input logic [7:0] hop, input logic taken);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = vld; wr_prefix = pfx;
        wr_len = 6'(len); wr_hop = hop;
        @(negedge clk);
        wr_en = 1'b0;
        if (taken) begin
            m_vld[idx] = vld; m_val[idx] = pfx; m_len[idx] = (len > 32) ? 32 : len;
            m_hop[idx] = hop;
        end
    endtask

    // issue one lookup, measure latency, compare against the model
    task automatic lookup(input string req, input logic [31:0] key, input int exp_lat);
        logic e_hit; int e_idx; int e_hop; int lat;
        model(mode, key, e_hit, e_idx, e_hop);
        srch_valid = 1'b1; srch_key = key;
        @(negedge clk);
        srch_valid = 1'b0;
        lat = 1;
        while (!res_valid && lat < 20) begin @(negedge clk); lat++; end
        check({req, " latency"}, lat, exp_lat);
        check({req, " hit"}, res_hit, e_hit);
        check({req, " idx"}, res_idx, e_idx);
        check({req, " hop"}, res_hop, e_hop);
        @(negedge clk);
        check("R8 valid pulse ends", res_valid, 0);
        check("R8 result held", res_idx, e_idx);
    endtask

    task automatic t_reset();
        check("reset busy", busy, 0);
        check("reset res_valid", res_valid, 0);
        check("R3 reset res_hit", res_hit, 0);
    endtask

    task automatic start_reload();
        reload_req = 1'b1;
        srch_valid = 1'b1; srch_key = 32'h0;
        @(negedge clk);
        reload_req = 1'b0; srch_valid = 1'b0;
        check("R4 busy in reload", busy, 1);
        check("R4 lookup dropped on reload", res_valid, 0);
        for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    endtask

    task automatic end_reload();
        reload_done = 1'b1;
        @(negedge clk);
        reload_done = 1'b0;
        check("R4 busy cleared", busy, 0);
    endtask

    task automatic t_ordered();
        mode = 1'b0;
        start_reload();
        write_entry(0, 1'b1, 32'h0A01_0200, 24, 8'd5, 1'b1);
        write_entry(1, 1'b1, 32'h0A01_0000, 16, 8'd6, 1'b1);
        write_entry(2, 1'b1, 32'h0A00_0000, 8,  8'd7, 1'b1);
        write_entry(3, 1'b1, 32'h0000_0000, 0,  8'd9, 1'b1);
        write_entry(4, 1'b0, 32'h0A01_0203, 32, 8'd11, 1'b1);
        end_reload();
        lookup("R2 /24 first", 32'h0A01_0203, 1);
        check("R3 invalid entry skipped", res_idx, 0);
        lookup("R2 /16", 32'h0A01_0909, 1);
        lookup("R1 /8", 32'h0AC8_0001, 1);
        lookup("R1 len0 default", 32'h0B00_0001, 1);
        check("R1 len0 index", res_idx, 3);
    endtask

    task automatic t_ordered_write_ignored();
        mode = 1'b0;
        write_entry(5, 1'b1, 32'h0B00_0000, 8, 8'd20, 1'b0);
        lookup("R4 idle write ignored", 32'h0B00_0001, 1);
        check("R4 hop unchanged", res_hop, 9);
    endtask

    task automatic t_reload_clears();
        mode = 1'b0;
        start_reload();
        write_entry(0, 1'b1, 32'hC0A8_0000, 16, 8'd3, 1'b1);
        end_reload();
        lookup("R3 miss after reload", 32'h0A01_0203, 1);
        check("R3 miss hit flag", res_hit, 0);
    endtask

    task automatic t_lenprio();
        mode = 1'b1;
        write_entry(1, 1'b1, 32'hC0A8_0500, 24, 8'd4, 1'b1);
        write_entry(2, 1'b1, 32'hC000_0000, 8,  8'd8, 1'b1);
        write_entry(3, 1'b1, 32'hC0A8_0507, 40, 8'd12, 1'b1);
        write_entry(6, 1'b1, 32'hC0A8_0500, 24, 8'd13, 1'b1);
        lookup("R5 /32 longest", 32'hC0A8_0507, 8);
        check("R1 len clamp exact", res_idx, 3);
        lookup("R5 tie lowest index", 32'hC0A8_0509, 8);
        check("R5 tie idx", res_idx, 1);
        lookup("R7 kept /16", 32'hC0A8_0909, 8);
        lookup("R5 /8", 32'hC009_0909, 8);
        lookup("R3 lenprio miss", 32'h0808_0808, 8);
        mode = 1'b0;
        lookup("R2 ordered same table", 32'hC0A8_0507, 1);
        check("R2 ordered picks index0", res_idx, 0);
    endtask

    task automatic t_busy_ignore();
        int pulses;
        mode = 1'b1;
        srch_valid = 1'b1; srch_key = 32'hC0A8_0507;
        @(negedge clk);
        srch_key = 32'h0808_0808;
        @(negedge clk);
        check("R6 busy during search", busy, 1);
        @(negedge clk);
        srch_valid = 1'b0;
        pulses = 0;
        for (int i = 0; i < 12; i++) begin
            if (res_valid) pulses++;
            @(negedge clk);
        end
        check("R6 single pulse", pulses, 1);
        check("R6 first key result", res_idx, 3);
        check("R6 busy back low", busy, 0);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_val[i] = '0; m_len[i] = 0; m_hop[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ordered();
        t_ordered_write_ignored();
        t_reload_clears();
        t_lenprio();
        t_busy_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule